// File: doc/BRIEF.md
# Host bus address decode and latch

This block sits at the front of a slave peripheral on a synchronous ISA/VLBus-style host bus. When the address strobe rises, it captures the word address, the address-enable qualifier and the four active-low byte enables. From those held values it works out three things: whether the cycle targets this device, which register offset inside the device's 16-byte window is meant, and which byte lanes take part together with how wide the access is.

A programmable base register holds the upper address bits of the window. A separate active-low local-device output compares the live bus against that base without any clocking, so board logic can steer transceivers early. In 32-bit bus mode, an active-low data chip select overrides local decoding and forces a full-width access to the data register. In 16-bit bus mode the two upper byte enables are treated as unconnected. A byte-enable pattern that the current mode does not allow raises an error flag instead of strobing lanes.

Top module: `hbus_decode`

## Requirements
- R1: On a clock edge where `ads_ni` is high and was low on the previous edge, the block captures `addr_i`, `aen_i` and `be_ni`. From the next cycle on, every decoded output except `local_dev_no` follows only those captured values, the live mode and chip select, and the base register, until the next rising strobe.
- R2: `base_wdata_i` loads the base register on a clock edge with `base_we_i` high. The register resets to zero.
- R3: `local_dev_no` is combinational and goes low exactly when the live `aen_i` is low and the live `addr_i[15:4]` equals the base register. A high `aen_i` (a DMA cycle) never makes it low.
- R4: With the chip-select override inactive, `hit_o` is high exactly when the captured address enable is low and the captured `addr[15:4]` equals the base register.
- R5: With `wide_mode_i` low (16-bit bus), the captured `be_ni[3:2]` are read as 1, `lane_o[3:2]` stay 0 and `dcs_ni` has no effect.
- R6: While hit and legal, `lane_o[k]` strobes byte lane k (bits 8k+7:8k). Single lanes give `width_o`=1, the pairs 0011 and 1100 of lanes give 2, and all four give 3. Upper-lane patterns are legal only when `wide_mode_i` is high.
- R7: A hit whose effective byte enables fit none of those patterns (including none asserted) sets `be_err_o`, with `lane_o`=0 and `width_o`=0. Without a hit, `lane_o`, `width_o` and `be_err_o` are all 0.
- R8: With `wide_mode_i` high and `dcs_ni` low, the block gives `hit_o`=1, `dreg_o`=1, `lane_o`=1111, `width_o`=3 and `be_err_o`=0, whatever the captured address, enable and byte enables are. Otherwise `dreg_o`=0.
- R9: `reg_off_o` equals the captured `addr_i[3:1]`.
- R10: After reset, `hit_o`, `lane_o`, `width_o`, `be_err_o` and `dreg_o` are 0 and `reg_off_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide_mode_i | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| base_we_i | input | 1 | Base register write enable |
| base_wdata_i | input | 12 | Base register write data (address bits 15:4) |
| ads_ni | input | 1 | Address strobe, captured on its rising edge |
| aen_i | input | 1 | Address enable, high marks a DMA cycle |
| addr_i | input | 15 | Word address bits 15:1 |
| be_ni | input | 4 | Byte enables, active low |
| dcs_ni | input | 1 | Data register chip select, active low |
| local_dev_no | output | 1 | Live window match, active low |
| hit_o | output | 1 | Captured cycle targets this device |
| dreg_o | output | 1 | Forced data register access |
| reg_off_o | output | 3 | Captured address bits 3:1 |
| lane_o | output | 4 | Byte lane strobes |
| width_o | output | 2 | 0 none, 1 byte, 2 half, 3 word |
| be_err_o | output | 1 | Byte-enable pattern illegal for mode |

## Verification
The assertions check on every cycle the properties that hold in every state. The captured offset changes only on a rising strobe. An error flag never comes with lane strobes. A DMA cycle never drives the live match low. In 16-bit mode the upper lanes stay quiet, and the chip-select override always yields a full word. Whether the hit and the lane pattern are correct for a given base, address and byte-enable combination is shown only by the bench's random and directed scenarios. The same goes for capture followed by live-bus changes, rewriting the base, and illegal patterns in each mode.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_HALF = 2'd2,
    ACC_WORD = 2'd3
  } acc_width_e;

  // aligned byte, half or full-word mask only
  function automatic logic mask_legal(input logic [LANES-1:0] m);
    int unsigned n;
    n = $countones(m);
    if (n == 1) return 1'b1;
    if (n == 2) return (m == 4'b0011) || (m == 4'b1100);
    if (n == LANES) return 1'b1;
    return 1'b0;
  endfunction

  function automatic acc_width_e mask_width(input logic [LANES-1:0] m);
    case ($countones(m))
      1: return ACC_BYTE;
      2: return ACC_HALF;
      4: return ACC_WORD;
      default: return ACC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hbus_strobe_latch.sv
module hbus_strobe_latch #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ads_ni,
  input  logic              aen_i,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [LANES-1:0]  be_ni,
  output logic              ads_q_o,
  output logic              aen_q_o,
  output logic [ADDR_W-1:1] addr_q_o,
  output logic [LANES-1:0]  be_q_o
);
  logic cap;

  assign cap = ads_ni & ~ads_q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ads_q_o  <= 1'b1;  // no phantom edge out of reset
      aen_q_o  <= 1'b1;
      addr_q_o <= '0;
      be_q_o   <= '1;
    end else begin
      ads_q_o <= ads_ni;
      if (cap) begin
        aen_q_o  <= aen_i;
        addr_q_o <= addr_i;
        be_q_o   <= be_ni;
      end
    end
  end
endmodule

// File: rtl/hbus_base_cmp.sv
module hbus_base_cmp #(
  parameter int CMP_W = 12
) (
  input  logic             aen_i,
  input  logic [CMP_W-1:0] addr_hi_i,
  input  logic [CMP_W-1:0] base_i,
  output logic             match_o
);
  assign match_o = ~aen_i & (addr_hi_i == base_i);
endmodule

// File: rtl/hbus_lane_dec.sv
module hbus_lane_dec
  import hbus_pkg::*;
(
  input  logic             wide_i,
  input  logic [LANES-1:0] be_ni,
  output logic [LANES-1:0] mask_o,
  output logic [1:0]       width_o,
  output logic             legal_o
);
  localparam int HALF = LANES / 2;

  logic [LANES-1:0] be_eff;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    if (k < HALF) begin : g_low
      assign be_eff[k] = be_ni[k];
    end else begin : g_high
      assign be_eff[k] = be_ni[k] | ~wide_i;  // unconnected in narrow mode
    end
  end

  assign mask_o  = ~be_eff;
  assign legal_o = mask_legal(mask_o);
  assign width_o = mask_width(mask_o);
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
  import hbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLK_LSB = 4,
  localparam int BASE_W = ADDR_W - BLK_LSB,
  localparam int OFF_W  = BLK_LSB - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_mode_i,
  input  logic              base_we_i,
  input  logic [BASE_W-1:0] base_wdata_i,
  input  logic              ads_ni,
  input  logic              aen_i,
  input  logic [ADDR_W-1:1] addr_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic              dcs_ni,
  output logic              local_dev_no,
  output logic              hit_o,
  output logic              dreg_o,
  output logic [OFF_W-1:0]  reg_off_o,
  output logic [LANES-1:0]  lane_o,
  output logic [1:0]        width_o,
  output logic              be_err_o
);
  logic [BASE_W-1:0] base_q;
  logic              ads_q;
  logic              aen_q;
  logic [ADDR_W-1:1] addr_q;
  logic [LANES-1:0]  be_q;
  logic              match_live, match_lat;
  logic [LANES-1:0]  mask_raw;
  logic [1:0]        width_raw;
  logic              legal;
  logic              force_dreg;
  logic              lane_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= '0;
    else if (base_we_i) base_q <= base_wdata_i;
  end

  hbus_strobe_latch #(.ADDR_W(ADDR_W), .LANES(LANES)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ads_ni  (ads_ni),
    .aen_i   (aen_i),
    .addr_i  (addr_i),
    .be_ni   (be_ni),
    .ads_q_o (ads_q),
    .aen_q_o (aen_q),
    .addr_q_o(addr_q),
    .be_q_o  (be_q)
  );

  hbus_base_cmp #(.CMP_W(BASE_W)) u_cmp_live (
    .aen_i    (aen_i),
    .addr_hi_i(addr_i[ADDR_W-1:BLK_LSB]),
    .base_i   (base_q),
    .match_o  (match_live)
  );

  hbus_base_cmp #(.CMP_W(BASE_W)) u_cmp_lat (
    .aen_i    (aen_q),
    .addr_hi_i(addr_q[ADDR_W-1:BLK_LSB]),
    .base_i   (base_q),
    .match_o  (match_lat)
  );

  hbus_lane_dec u_lane (
    .wide_i (wide_mode_i),
    .be_ni  (be_q),
    .mask_o (mask_raw),
    .width_o(width_raw),
    .legal_o(legal)
  );

  assign local_dev_no = ~match_live;
  assign force_dreg   = wide_mode_i & ~dcs_ni;
  assign lane_ok      = match_lat & legal;

  assign dreg_o    = force_dreg;
  assign hit_o     = force_dreg | match_lat;
  assign reg_off_o = addr_q[BLK_LSB-1:1];
  assign lane_o    = force_dreg ? '1 : (lane_ok ? mask_raw : '0);
  assign width_o   = force_dreg ? 2'(ACC_WORD) : (lane_ok ? width_raw : 2'(ACC_NONE));
  assign be_err_o  = ~force_dreg & match_lat & ~legal;
endmodule

// File: rtl/hbus_decode_chk.sv
module hbus_decode_chk #(
  parameter int ADDR_W  = 16,
  parameter int BLK_LSB = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wide_mode_i,
  input logic                 ads_ni,
  input logic                 ads_q,
  input logic                 aen_i,
  input logic                 dcs_ni,
  input logic [ADDR_W-1:1]    addr_i,
  input logic                 local_dev_no,
  input logic                 hit_o,
  input logic                 dreg_o,
  input logic [BLK_LSB-2:0]   reg_off_o,
  input logic [3:0]           lane_o,
  input logic [1:0]           width_o,
  input logic                 be_err_o
);
  AST_CAPTURE_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ads_ni && !ads_q) |=> reg_off_o == $past(addr_i[BLK_LSB-1:1])); // R1
  AST_HOLD_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ads_ni && !ads_q) |=> $stable(reg_off_o)); // R9
  AST_DMA_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_i |-> local_dev_no); // R3
  AST_NARROW_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_mode_i |-> (lane_o[3:2] == 2'b00 && !dreg_o)); // R5
  AST_ERR_NO_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_err_o |-> (lane_o == 4'b0 && width_o == 2'd0 && hit_o)); // R7
  AST_FORCE_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_mode_i && !dcs_ni) |-> (hit_o && dreg_o && lane_o == 4'hF && width_o == 2'd3)); // R8
  AST_BYTE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    width_o == 2'd1 |-> $onehot0(lane_o) && lane_o != 4'b0); // R6
  AST_NO_HIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (lane_o == 4'b0 && !be_err_o)); // R7
endmodule

bind hbus_decode hbus_decode_chk #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wide_mode_i (wide_mode_i),
  .ads_ni      (ads_ni),
  .ads_q       (ads_q),
  .aen_i       (aen_i),
  .dcs_ni      (dcs_ni),
  .addr_i      (addr_i),
  .local_dev_no(local_dev_no),
  .hit_o       (hit_o),
  .dreg_o      (dreg_o),
  .reg_off_o   (reg_off_o),
  .lane_o      (lane_o),
  .width_o     (width_o),
  .be_err_o    (be_err_o)
);

// File: tb/sim_hbus_decode.sv
`timescale 1ns/1ps
module sim_hbus_decode;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wide_mode_i = 1'b1;
  logic        base_we_i = 1'b0;
  logic [11:0] base_wdata_i = '0;
  logic        ads_ni = 1'b1;
  logic        aen_i = 1'b1;
  logic [15:1] addr_i = '0;
  logic [3:0]  be_ni = 4'hF;
  logic        dcs_ni = 1'b1;
  logic        local_dev_no, hit_o, dreg_o, be_err_o;
  logic [2:0]  reg_off_o;
  logic [3:0]  lane_o;
  logic [1:0]  width_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench copies of the programmed and captured state
  logic [11:0] m_base = '0;
  logic        m_aen  = 1'b1;
  logic [15:1] m_addr = '0;
  logic [3:0]  m_be   = 4'hF;

  always #4 clk_i = ~clk_i;

  hbus_decode u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {dreg, err, hit, width[1:0], lanes[3:0]}
  function automatic logic [8:0] model(input logic wide, input logic dcs, input logic aen,
                                       input logic [11:0] ahi, input logic [3:0] be,
                                       input logic [11:0] base);
    logic [3:0] b;
    if (wide && !dcs) return {1'b1, 1'b0, 1'b1, 2'd3, 4'hF};
    if (aen || ahi != base) return '0;
    b = wide ? be : {2'b11, be[1:0]};
    case (b)
      4'b1110: return {3'b001, 2'd1, 4'b0001};
      4'b1101: return {3'b001, 2'd1, 4'b0010};
      4'b1011: return {3'b001, 2'd1, 4'b0100};
      4'b0111: return {3'b001, 2'd1, 4'b1000};
      4'b1100: return {3'b001, 2'd2, 4'b0011};
      4'b0011: return {3'b001, 2'd2, 4'b1100};
      4'b0000: return {3'b001, 2'd3, 4'b1111};
      default: return {3'b011, 2'd0, 4'b0000};
    endcase
  endfunction

  task automatic write_base(input logic [11:0] v);
    @(negedge clk_i);
    base_we_i = 1'b1; base_wdata_i = v;
    @(negedge clk_i);
    base_we_i = 1'b0;
    m_base = v;
  endtask

  task automatic strobe(input logic [15:1] a, input logic aen, input logic [3:0] be);
    @(negedge clk_i);
    ads_ni = 1'b0; addr_i = a; aen_i = aen; be_ni = be;
    @(negedge clk_i);
    ads_ni = 1'b1;
    @(negedge clk_i);
    m_addr = a; m_aen = aen; m_be = be;
  endtask

  task automatic check_all(input string tag);
    logic [8:0] e;
    logic       ld;
    #1;
    e  = model(wide_mode_i, dcs_ni, m_aen, m_addr[15:4], m_be, m_base);
    ld = !(!aen_i && addr_i[15:4] == m_base);
    chk(hit_o == e[6],     {tag, " R4 hit"},      hit_o,     e[6]);
    chk(lane_o == e[3:0],  {tag, " R6 lanes"},    lane_o,    e[3:0]);
    chk(width_o == e[5:4], {tag, " R6 width"},    width_o,   e[5:4]);
    chk(be_err_o == e[7],  {tag, " R7 err"},      be_err_o,  e[7]);
    chk(dreg_o == e[8],    {tag, " R8 dreg"},     dreg_o,    e[8]);
    chk(reg_off_o == m_addr[3:1], {tag, " R9 off"}, reg_off_o, m_addr[3:1]);
    chk(local_dev_no == ld, {tag, " R3 ldev"},    local_dev_no, ld);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(hit_o == 0 && lane_o == 0 && width_o == 0 && !be_err_o && !dreg_o && reg_off_o == 0,
        "R10 reset outputs", {hit_o, lane_o, width_o, be_err_o, dreg_o}, 0);
    rst_ni = 1'b1;
    // R2 base resets to zero: live address 0 with aen low matches
    @(negedge clk_i); aen_i = 1'b0; addr_i = '0; #1;
    chk(local_dev_no == 0, "R2 base reset zero", local_dev_no, 0);
    aen_i = 1'b1; #1;
    chk(local_dev_no == 1, "R3 dma no match", local_dev_no, 1);

    write_base(12'h3A5);
    aen_i = 1'b0; addr_i = {12'h3A5, 3'd0}; #1;
    chk(local_dev_no == 0, "R2 base written", local_dev_no, 0);

    // R1/R4 capture then scramble live bus
    strobe({12'h3A5, 3'd5}, 1'b0, 4'b1100);
    addr_i = '1; aen_i = 1'b1; be_ni = 4'b0101;
    check_all("R1 hold");
    @(negedge clk_i); check_all("R1 hold2");
    // R4 dma capture
    strobe({12'h3A5, 3'd2}, 1'b1, 4'b1110);
    check_all("R4 dma");
    // R5 narrow: be 0000 becomes lower half, 0011 illegal, dcs ignored
    wide_mode_i = 1'b0;
    strobe({12'h3A5, 3'd1}, 1'b0, 4'b0000);
    check_all("R5 narrow word");
    chk(lane_o == 4'b0011, "R5 narrow half", lane_o, 4'b0011);
    strobe({12'h3A5, 3'd1}, 1'b0, 4'b0011);
    dcs_ni = 1'b0;
    check_all("R5 narrow upper");
    chk(be_err_o == 1, "R7 narrow upper err", be_err_o, 1);
    dcs_ni = 1'b1;
    // R8 forced data register on miss
    wide_mode_i = 1'b1;
    strobe({12'h001, 3'd0}, 1'b1, 4'b1010);
    dcs_ni = 1'b0;
    check_all("R8 force");
    dcs_ni = 1'b1;
    check_all("R8 release");
    // R7 none asserted while hit
    strobe({12'h3A5, 3'd7}, 1'b0, 4'b1111);
    check_all("R7 none");
    // R2 rewrite base moves window
    write_base(12'h001);
    check_all("R2 rewrite");

    for (int i = 0; i < 600; i++) begin
      logic [15:1] a;
      a = 15'($urandom);
      if ($urandom_range(0, 1) == 1) a[15:4] = m_base;
      if ($urandom_range(0, 15) == 0) write_base(($urandom_range(0, 1) == 1) ? a[15:4] : 12'($urandom));
      wide_mode_i = 1'($urandom);
      strobe(a, ($urandom_range(0, 3) == 0), 4'($urandom));
      dcs_ni = ($urandom_range(0, 3) != 0);
      addr_i = 15'($urandom);
      if ($urandom_range(0, 1) == 1) addr_i[15:4] = m_base;
      aen_i = 1'($urandom); be_ni = 4'($urandom);
      check_all("rand");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule